// File: doc/BRIEF.md
# Serial TDM Receiver with Programmable Input Delay

This block takes in one serial time-division-multiplexed stream. The stream carries 512 byte channels per frame at a bit rate one quarter of the block clock, so each bit lasts four clock cycles. A one-cycle frame pulse marks the start of each frame. Inside the block, a frame reference is delayed by a programmed number of quarter-bit cycles. The block then samples the line once per bit at a chosen quarter of the bit cell and reassembles each channel's eight bits, most significant bit first. Each completed byte is presented with its channel number and a one-cycle valid strobe.

The 5-bit delay code can be read in two ways, and a mode input selects which. In fractional mode the whole code is a delay in quarter bits. In phase mode the upper three bits give a whole-bit delay and the lower two bits choose the sampling quarter. The block picks up a new code only on a frame pulse, so the bytes already in flight keep the timing they started with.

Top module: `tdm_bit_delay_rx`

## Requirements
- R1: While reset is asserted, and after reset until the first frame pulse, valid_o is 0; chan_o and byte_o are 0 in reset.
- R2: With samp_mode_i = 0 and delay code D (0 to 31), the data line is taken as delayed by D cycles, and bit k of the frame (counting from 0) is sampled D+2+4k cycles after the cycle in which frame_i is high, which is the 3/4 point of the delayed bit.
- R3: With samp_mode_i = 1, code bits [4:2] give a whole-bit delay W of 0 to 7, which moves the data window by 4W cycles.
- R4: With samp_mode_i = 1, code bits [1:0] set the sampling quarter within the delayed bit: 00 selects the 3/4 point (offset 2 cycles), 01 the 4/4 point (offset 3), 10 the 1/4 point (offset 0) and 11 the 2/4 point (offset 1).
- R5: Code 0 gives the same timing in both modes: no delay and sampling at the 3/4 point.
- R6: Each frame produces channels 0 to 511 in increasing order. Each byte is assembled with the first received bit as bit 7.
- R7: valid_o is a single-cycle pulse. It is high in the cycle after the eighth bit of a channel is sampled, and at that time chan_o and byte_o hold that channel.
- R8: With a delay of 7 1/2 bits or more, the last channel of a frame is still sampled and reported after the next frame pulse.
- R9: A change of code or mode takes effect only at a frame pulse. A restart that cuts a channel short emits no byte for that channel.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock at four times the bit rate |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_i | input | 1 | One-cycle frame start pulse |
| ser_i | input | 1 | Serial TDM data |
| samp_mode_i | input | 1 | 0: fractional delay, 1: whole-bit delay plus sampling quarter |
| delay_i | input | 5 | Delay code |
| valid_o | output | 1 | One-cycle strobe for a completed byte |
| chan_o | output | 9 | Channel number of the byte |
| byte_o | output | 8 | Received byte |

## Verification
A wrong quarter-cycle counter or a wrong latched tap moves every strobe of the affected frame. That error appears on the first byte strobe, 29 to 62 cycles after the frame pulse. A wrong sampling phase shows first as corrupted byte values wherever adjacent bits differ, which happens within the first channel. A bad position counter or a bad frame-end stop shows as skipped or extra channel numbers, or as a byte strobe from a truncated channel, at the next frame boundary. The bench changes the code in the middle of a frame and uses delays near the maximum, so that these boundary errors are exposed.

// File: rtl/tdm_rx_pkg.sv
package tdm_rx_pkg;
  localparam int CODE_W   = 5;
  localparam int TAP_W    = 6;
  localparam int BYTE_W   = 8;
  localparam int QPB_LOG  = 2;
  localparam int BIT_LOG  = 3;
  localparam int TAP_MAX  = (1 << CODE_W) + 1;

  // sampling quarter offset for phase mode select bits
  function automatic logic [1:0] phase_off(input logic [1:0] sel);
    case (sel)
      2'b00:   return 2'd2;
      2'b01:   return 2'd3;
      2'b10:   return 2'd0;
      default: return 2'd1;
    endcase
  endfunction
endpackage

// File: rtl/tdm_delay_decode.sv
module tdm_delay_decode
  import tdm_rx_pkg::*;
(
  input  logic              mode_i,
  input  logic [CODE_W-1:0] code_i,
  output logic [TAP_W-1:0]  tap_o
);
  always_comb begin
    if (mode_i) tap_o = TAP_W'({code_i[CODE_W-1:2], phase_off(code_i[1:0])});
    else        tap_o = TAP_W'(code_i) + TAP_W'(2);
  end
endmodule

// File: rtl/tdm_frame_ref.sv
module tdm_frame_ref
  import tdm_rx_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             frame_i,
  input  logic [TAP_W-1:0] tap_i,
  output logic             dstart_o
);
  logic [TAP_W-1:0] qcnt_q, tap_q, q_now, tap_eff;

  always_comb begin
    q_now    = frame_i ? '0 : qcnt_q;
    tap_eff  = frame_i ? tap_i : tap_q;
    dstart_o = (q_now == tap_eff);
  end

  // qcnt saturates above any tap, so no restart before the first frame
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      qcnt_q <= '1;
      tap_q  <= TAP_W'(2);
    end else if (frame_i) begin
      qcnt_q <= TAP_W'(1);
      tap_q  <= tap_i;
    end else if (qcnt_q != '1) begin
      qcnt_q <= qcnt_q + TAP_W'(1);
    end
  end

  // R9
  tap_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_i |=> $stable(tap_q));
  // R2
  tap_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(tap_eff) <= TAP_MAX);
  // R9
  one_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dstart_o |=> !dstart_o);
endmodule

// File: rtl/tdm_byte_sampler.sv
module tdm_byte_sampler
  import tdm_rx_pkg::*;
#(
  parameter int N_CHAN = 512
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      ser_i,
  input  logic                      dstart_i,
  output logic                      valid_o,
  output logic [$clog2(N_CHAN)-1:0] chan_o,
  output logic [BYTE_W-1:0]         byte_o
);
  localparam int CH_W  = $clog2(N_CHAN);
  localparam int SUB_W = QPB_LOG + BIT_LOG;
  localparam int POS_W = CH_W + SUB_W;
  localparam logic [POS_W-1:0] LAST = POS_W'(N_CHAN * (1 << SUB_W) - 1);

  logic [POS_W-1:0]  pos_q, pos_now;
  logic              run_q, active, samp;
  logic [BYTE_W-1:0] sh_q, sh_next;
  logic [CH_W-1:0]   last_chan_q;

  always_comb begin
    pos_now = dstart_i ? '0 : pos_q;
    active  = dstart_i | run_q;
    samp    = active && (pos_now[QPB_LOG-1:0] == '0);
    sh_next = {sh_q[BYTE_W-2:0], ser_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q   <= '0;
      run_q   <= 1'b0;
      sh_q    <= '0;
      valid_o <= 1'b0;
      chan_o  <= '0;
      byte_o  <= '0;
    end else begin
      valid_o <= 1'b0;
      if (active) begin
        pos_q <= pos_now + POS_W'(1);
        run_q <= (pos_now != LAST);
      end
      if (samp) begin
        sh_q <= sh_next;
        if (pos_now[SUB_W-1:QPB_LOG] == '1) begin
          valid_o <= 1'b1;
          byte_o  <= sh_next;
          chan_o  <= pos_now[POS_W-1:SUB_W];
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      last_chan_q <= '0;
    else if (valid_o) last_chan_q <= chan_o;
  end

  // R7
  valid_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);
  // R6
  chan_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && chan_o != '0) |-> (chan_o == last_chan_q + CH_W'(1)));
  // R1
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_q && !dstart_i) |=> !valid_o);
endmodule

// File: rtl/tdm_bit_delay_rx.sv
module tdm_bit_delay_rx
  import tdm_rx_pkg::*;
#(
  parameter int N_CHAN = 512
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      frame_i,
  input  logic                      ser_i,
  input  logic                      samp_mode_i,
  input  logic [CODE_W-1:0]         delay_i,
  output logic                      valid_o,
  output logic [$clog2(N_CHAN)-1:0] chan_o,
  output logic [BYTE_W-1:0]         byte_o
);
  logic [TAP_W-1:0] tap;
  logic             dstart;

  tdm_delay_decode u_dec (
    .mode_i (samp_mode_i),
    .code_i (delay_i),
    .tap_o  (tap)
  );

  tdm_frame_ref u_ref (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .frame_i  (frame_i),
    .tap_i    (tap),
    .dstart_o (dstart)
  );

  tdm_byte_sampler #(.N_CHAN(N_CHAN)) u_smp (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ser_i    (ser_i),
    .dstart_i (dstart),
    .valid_o  (valid_o),
    .chan_o   (chan_o),
    .byte_o   (byte_o)
  );
endmodule

// File: tb/tdm_bit_delay_rx_tb_top.sv
module tdm_bit_delay_rx_tb_top;
  localparam int N_CHAN = 512;
  localparam int FQ     = N_CHAN * 32;
  localparam int NF     = 8;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       frame_i = 1'b0;
  logic       ser_i = 1'b0;
  logic       samp_mode_i = 1'b0;
  logic [4:0] delay_i = 5'd0;
  logic       valid_o;
  logic [8:0] chan_o;
  logic [7:0] byte_o;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  int s_f[NF];
  int t_f[NF];
  int d_f[NF];
  int salt[NF];
  logic       m_f[NF];
  logic [4:0] c_f[NF];
  bit late_seen = 1'b0;

  tdm_bit_delay_rx dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .frame_i(frame_i), .ser_i(ser_i),
    .samp_mode_i(samp_mode_i), .delay_i(delay_i),
    .valid_o(valid_o), .chan_o(chan_o), .byte_o(byte_o)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic int off_of(input logic [1:0] s);
    case (s)
      2'b00: return 2;
      2'b01: return 3;
      2'b10: return 0;
      default: return 1;
    endcase
  endfunction

  function automatic int dly_of(input logic m, input logic [4:0] c);
    return m ? int'(c[4:2]) * 4 : int'(c);
  endfunction

  function automatic int tap_of(input logic m, input logic [4:0] c);
    return m ? int'(c[4:2]) * 4 + off_of(c[1:0]) : int'(c) + 2;
  endfunction

  function automatic logic [7:0] byte_of(input int f, input int c);
    logic [7:0] v;
    v = 8'(salt[f]) ^ 8'(c * 157);
    return v + 8'(c >> 1);
  endfunction

  function automatic logic stream_bit(input int g);
    for (int fr = NF - 1; fr >= 0; fr--) begin
      int p;
      p = g - (s_f[fr] + d_f[fr]);
      if (p >= 0 && p < FQ) begin
        logic [7:0] b;
        b = byte_of(fr, (p / 4) / 8);
        return b[7 - ((p / 4) % 8)];
      end
    end
    return 1'b0;
  endfunction

  function automatic string tag_of(input int f);
    case (f)
      0: return "R2";
      1: return "R4";
      2: return "R8";
      3: return "R2";
      4: return "R3";
      5: return "R9";
      6: return "R5";
      default: return "R2";
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic monitor(input int cur);
    bit ev;
    int ef, ec;
    ev = 1'b0; ef = 0; ec = 0;
    for (int fr = 0; fr < NF; fr++) begin
      int r;
      r = cur - (s_f[fr] + t_f[fr] + 28);
      if (r >= 0 && (r % 32) == 0 && (r / 32) < N_CHAN) begin
        if (fr == NF - 1 || cur < s_f[fr + 1] + t_f[fr + 1]) begin
          ev = 1'b1; ef = fr; ec = r / 32;
        end
      end
    end
    if (ev) begin
      bit clean;
      clean = (ef == NF - 1) || (cur < s_f[ef + 1] + d_f[ef + 1]);
      chk(valid_o == 1'b1, {tag_of(ef), " R7 strobe"}, int'(valid_o), 1);
      chk(int'(chan_o) == ec, "R6 channel", int'(chan_o), ec);
      if (clean)
        chk(byte_o == byte_of(ef, ec), {tag_of(ef), " byte"}, int'(byte_o), int'(byte_of(ef, ec)));
      if (ef == 2 && ec == N_CHAN - 1 && cur > s_f[3]) late_seen = 1'b1;
    end else if (valid_o) begin
      chk(1'b0, "R9 R7 unexpected strobe", int'(chan_o), 0);
    end
  endtask

  task automatic apply_cfg(input int f);
    samp_mode_i = m_f[f];
    delay_i     = c_f[f];
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    int s0, done_cyc;
    void'($urandom(32'h1c0de));
    m_f[0] = 1'b0; c_f[0] = 5'd0;
    m_f[1] = 1'b1; c_f[1] = 5'b00011;
    m_f[2] = 1'b0; c_f[2] = 5'd31;
    m_f[3] = 1'b0; c_f[3] = 5'd30;
    m_f[4] = 1'b1; c_f[4] = 5'b11101;
    m_f[5] = 1'b1; c_f[5] = 5'b00010;
    m_f[6] = 1'b1; c_f[6] = 5'b00000;
    m_f[7] = 1'($urandom % 2); c_f[7] = 5'($urandom % 32);
    for (int f = 0; f < NF; f++) begin
      salt[f] = int'($urandom % 256);
      t_f[f]  = tap_of(m_f[f], c_f[f]);
      d_f[f]  = dly_of(m_f[f], c_f[f]);
    end
    // R5: code 0 gives the same tap in both modes
    chk(tap_of(1'b1, 5'd0) == tap_of(1'b0, 5'd0), "R5 model", tap_of(1'b1, 5'd0), 2);

    repeat (4) @(negedge clk);
    chk(valid_o == 1'b0, "R1 valid in reset", int'(valid_o), 0);
    chk(chan_o == 9'd0, "R1 chan in reset", int'(chan_o), 0);
    chk(byte_o == 8'd0, "R1 byte in reset", int'(byte_o), 0);
    rst_ni = 1'b1;
    s0 = cyc + 20;
    for (int f = 0; f < NF; f++) s_f[f] = s0 + f * FQ;
    apply_cfg(0);
    done_cyc = s_f[NF - 1] + FQ + 80;
    while (cyc < done_cyc) begin
      @(negedge clk);
      monitor(cyc);
      if (cyc == s0 - 1) chk(valid_o == 1'b0, "R1 idle before frame", int'(valid_o), 0);
      frame_i = 1'b0;
      for (int f = 0; f < NF; f++) begin
        if (cyc + 1 == s_f[f]) frame_i = 1'b1;
        if (f > 0 && cyc + 1 == s_f[f] - 100) apply_cfg(f);
      end
      ser_i = stream_bit(cyc + 1);
    end
    chk(late_seen, "R8 last channel after next frame pulse", int'(late_seen), 1);
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 200000);
    finish_run();
  end
endmodule